// File: doc/BRIEF.md
# Host-to-DMA Word FIFO Bridge

This block buffers 16-bit words written by a host processor and hands them to channel 0 of a second processor's DMA engine. The host sets a transfer length, turns on request mode, and streams words into an eight-entry FIFO. Once a group of four words has gathered and the channel is armed, the bridge drains every buffered word. Each word is written to the destination address, which then moves up by two bytes, and the length and transfer counters each count down by one. Status outputs show when the FIFO is full, when the transfer has finished, and when the channel has reached its normal end.

Host words arrive on a valid/ready stream. A word is taken on any cycle where both `in_valid` and `in_ready` are high. When request mode is off, `in_ready` still accepts the word but the word is discarded, so the host never stalls. `in_ready` falls while the FIFO is full, while a drain is running, and in the one cycle where a drain is about to start. Drained words leave on a second valid/ready stream. While `out_ready` is low, the word and its address stay frozen on the outputs. Register and channel-setup writes are plain strobes that apply in one cycle.

Top module: `host_dma_fifo_bridge`

## Requirements
- R1: A host register write with `reg_sel`=0 loads the length register with `reg_wdata` and forces its two low bits to zero.
- R2: A host register write with `reg_sel`=1 sets request mode from `reg_wdata` bit 2 and reverse mode from bit 0, and leaves the FIFO-full flag unchanged.
- R3: A word is stored only when `in_valid` and `in_ready` are both high and request mode is on. An accepted word with request mode off is dropped and never appears at the drain output.
- R4: `in_ready` is low while the FIFO is full, while a drain runs, and in the cycle where a drain start is pending.
- R5: A drain starts one cycle after the stored-word count is a nonzero multiple of 4 while `ch_mode`=2'b01 and `dma_en`=1. With any other mode, or with `dma_en` low, the words stay buffered.
- R6: Each drain beat (`out_valid` and `out_ready` both high) presents the oldest unsent word at the current destination address. After the beat, the address is 2 higher and both the length register and the transfer count are 1 lower. While `out_ready` is low, `out_valid`, `out_addr` and `out_data` hold steady.
- R7: A drain ends once every stored word has been sent or the transfer count is zero. Unsent words are discarded, and the FIFO is left empty with the full flag clear.
- R8: If the length register is zero when a drain ends, request mode is cleared.
- R9: If the transfer count is zero when a drain ends, `ch_end` is set. A channel setup write (`cfg_we`) clears `ch_end`.
- R10: `fifo_full` sets when the stored-word count reaches the depth of 8, and no word is stored beyond that.
- R11: Host register writes and channel setup writes are ignored while `busy` is high.
- R12: After reset, all counters, the address and all flags are zero, `in_ready` is 1 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Host register write strobe |
| reg_sel | input | 2 | 0 = length, 1 = request control |
| reg_wdata | input | 16 | Host register write data |
| cfg_we | input | 1 | Channel setup strobe |
| cfg_dst | input | 32 | Destination address to load |
| cfg_cnt | input | 24 | Transfer count to load |
| ch_mode | input | 2 | Channel control low field; 2'b01 arms the drain |
| dma_en | input | 1 | Global DMA enable |
| in_valid | input | 1 | Host word valid |
| in_ready | output | 1 | Bridge can take a host word |
| in_data | input | 16 | Host word |
| out_valid | output | 1 | Drain word valid |
| out_ready | input | 1 | Target accepts drain word |
| out_addr | output | 32 | Destination address of drain word |
| out_data | output | 16 | Drain word |
| busy | output | 1 | Drain in progress |
| fifo_full | output | 1 | FIFO full flag |
| req_en | output | 1 | Request mode flag |
| rev_mode | output | 1 | Reverse mode flag |
| len_left | output | 16 | Length register |
| xfer_left | output | 24 | Transfer count |
| ch_end | output | 1 | Channel normal-end flag |

## Verification
The assertions assume the host follows the stream rules. This means `in_data` is only meaningful while `in_valid` is high, and the target only samples `out_data` on a beat. They also assume `ch_mode` and `dma_en` may change at any time, since the start test reads them afresh on every idle cycle. The stimulus holds each host word until it is taken. It changes register and setup values only between clock edges, and it keeps the length register at least as large as the words sent during the directed phase, so the length never counts below zero. The random phase toggles the arm inputs and `out_ready` freely.

// File: rtl/fifo_bridge_pkg.sv
package fifo_bridge_pkg;
  typedef enum logic {
    DS_IDLE  = 1'b0,
    DS_DRAIN = 1'b1
  } drain_state_e;

  localparam logic [1:0] SEL_LENGTH  = 2'd0;
  localparam logic [1:0] SEL_REQCTL  = 2'd1;
  localparam int         BIT_REQ     = 2;
  localparam int         BIT_REV     = 0;
  localparam logic [1:0] MODE_ARMED  = 2'b01;
endpackage

// File: rtl/bridge_word_store.sv
module bridge_word_store #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH + 1),
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          clear,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0]  rd_data,
  output logic [PW-1:0] count
);
  logic [W-1:0] slot [DEPTH];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (push && count[IW-1:0] == IW'(g) && count < PW'(DEPTH))
          slot[g] <= push_data;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (clear) count <= '0;
    else if (push)  count <= count + 1'b1;
  end

  assign rd_data = slot[rd_idx];

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> count < PW'(DEPTH));
endmodule

// File: rtl/bridge_drain_seq.sv
module bridge_drain_seq
  import fifo_bridge_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [PW-1:0] count,
  input  logic          tcnt_zero,
  input  logic          out_ready,
  output logic          busy,
  output logic [PW-1:0] rd_ptr,
  output logic          out_valid,
  output logic          beat,
  output logic          done
);
  drain_state_e st;
  logic         more;

  assign busy      = (st == DS_DRAIN);
  assign more      = (rd_ptr < count) && !tcnt_zero;
  assign out_valid = busy && more;
  assign beat      = out_valid && out_ready;
  assign done      = busy && !more;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= DS_IDLE;
      rd_ptr <= '0;
    end else begin
      case (st)
        DS_IDLE: if (start) begin
          st     <= DS_DRAIN;
          rd_ptr <= '0;
        end
        DS_DRAIN: begin
          if (beat) rd_ptr <= rd_ptr + 1'b1;
          if (done) st <= DS_IDLE;
        end
        default: st <= DS_IDLE;
      endcase
    end
  end

  assert_hold_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(rd_ptr)));
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: rtl/bridge_regs.sv
module bridge_regs
  import fifo_bridge_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 24,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [LW-1:0] reg_wdata,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_dst,
  input  logic [CW-1:0] cfg_cnt,
  input  logic          busy,
  input  logic          beat,
  input  logic          done,
  input  logic          set_full,
  output logic [LW-1:0] len,
  output logic          req_en,
  output logic          rev,
  output logic          full,
  output logic [AW-1:0] dst,
  output logic [CW-1:0] tcnt,
  output logic          ch_end
);
  logic host_wr, cfg_wr;
  assign host_wr = reg_we && !busy;
  assign cfg_wr  = cfg_we && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len    <= '0;
      req_en <= 1'b0;
      rev    <= 1'b0;
      full   <= 1'b0;
      dst    <= '0;
      tcnt   <= '0;
      ch_end <= 1'b0;
    end else begin
      if (beat) begin
        len  <= len - 1'b1;
        dst  <= dst + AW'(2);
        tcnt <= tcnt - 1'b1;
      end else begin
        if (host_wr && reg_sel == SEL_LENGTH)
          len <= {reg_wdata[LW-1:2], 2'b00};
        if (cfg_wr) begin
          dst  <= cfg_dst;
          tcnt <= cfg_cnt;
        end
      end
      if (host_wr && reg_sel == SEL_REQCTL) begin
        req_en <= reg_wdata[BIT_REQ];
        rev    <= reg_wdata[BIT_REV];
      end else if (done && len == '0) begin
        req_en <= 1'b0;
      end
      if (done)          full <= 1'b0;
      else if (set_full) full <= 1'b1;
      if (done && tcnt == '0) ch_end <= 1'b1;
      else if (cfg_wr)        ch_end <= 1'b0;
    end
  end

  assert_len_align_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !busy && reg_sel == SEL_LENGTH) |=> len[1:0] == 2'b00);
  assert_req_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && len == '0) |=> !req_en);
  assert_end_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && tcnt == '0) |=> ch_end);
  assert_busy_cfg_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !beat) |=> ($stable(dst) && $stable(tcnt)));
  assert_full_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == SEL_REQCTL && !done && !set_full) |=> $stable(full));
endmodule

// File: rtl/host_dma_fifo_bridge.sv
module host_dma_fifo_bridge
  import fifo_bridge_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  parameter int GROUP = 4,
  parameter int AW    = 32,
  parameter int CW    = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [W-1:0]  reg_wdata,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_dst,
  input  logic [CW-1:0] cfg_cnt,
  input  logic [1:0]    ch_mode,
  input  logic          dma_en,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_addr,
  output logic [W-1:0]  out_data,
  output logic          busy,
  output logic          fifo_full,
  output logic          req_en,
  output logic          rev_mode,
  output logic [W-1:0]  len_left,
  output logic [CW-1:0] xfer_left,
  output logic          ch_end
);
  localparam int PW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);
  localparam int GW = $clog2(GROUP);

  logic [PW-1:0] count;
  logic [PW-1:0] rd_ptr;
  logic          start, push, set_full, beat, done;

  assign start    = !busy && count != '0 && count[GW-1:0] == '0 &&
                    ch_mode == MODE_ARMED && dma_en;
  assign in_ready = !busy && count < PW'(DEPTH) && !start;
  assign push     = in_valid && in_ready && req_en;
  assign set_full = push && count == PW'(DEPTH - 1);

  bridge_word_store #(.W(W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(in_data),
    .clear(done), .rd_idx(rd_ptr[IW-1:0]), .rd_data(out_data), .count(count)
  );

  bridge_drain_seq #(.DEPTH(DEPTH)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .count(count),
    .tcnt_zero(xfer_left == '0), .out_ready(out_ready), .busy(busy),
    .rd_ptr(rd_ptr), .out_valid(out_valid), .beat(beat), .done(done)
  );

  bridge_regs #(.AW(AW), .CW(CW), .LW(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .cfg_we(cfg_we), .cfg_dst(cfg_dst),
    .cfg_cnt(cfg_cnt), .busy(busy), .beat(beat), .done(done),
    .set_full(set_full), .len(len_left), .req_en(req_en), .rev(rev_mode),
    .full(fifo_full), .dst(out_addr), .tcnt(xfer_left), .ch_end(ch_end)
  );

  assert_full_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !in_ready);
  assert_drop_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !req_en && !done) |=> $stable(count));
  assert_start_arm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ch_mode != MODE_ARMED) |=> !busy);
endmodule

// File: tb/host_dma_fifo_bridge_test.sv
module host_dma_fifo_bridge_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [15:0] reg_wdata = '0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_dst = '0;
  logic [23:0] cfg_cnt = '0;
  logic [1:0]  ch_mode = '0;
  logic        dma_en = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        out_ready = 1'b0;
  logic        in_ready, out_valid, busy, fifo_full, req_en, rev_mode, ch_end;
  logic [31:0] out_addr;
  logic [15:0] out_data, len_left;
  logic [23:0] xfer_left;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  host_dma_fifo_bridge uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .cfg_we(cfg_we), .cfg_dst(cfg_dst),
    .cfg_cnt(cfg_cnt), .ch_mode(ch_mode), .dma_en(dma_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_data(out_data), .busy(busy), .fifo_full(fifo_full),
    .req_en(req_en), .rev_mode(rev_mode), .len_left(len_left),
    .xfer_left(xfer_left), .ch_end(ch_end)
  );

  // Behavioural reference model
  logic [15:0] mq[$];
  bit          m_busy, m_req, m_rev, m_full, m_end;
  int          m_rd;
  logic [15:0] m_len;
  logic [23:0] m_tc;
  logic [31:0] m_dst;

  function automatic bit m_start();
    return !m_busy && mq.size() != 0 && (mq.size() % 4) == 0 &&
           ch_mode == 2'b01 && dma_en;
  endfunction
  function automatic bit m_inrdy();
    return !m_busy && mq.size() < 8 && !m_start();
  endfunction
  function automatic bit m_ov();
    return m_busy && m_rd < mq.size() && m_tc != 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); m_busy = 0; m_req = 0; m_rev = 0; m_full = 0; m_end = 0;
      m_rd = 0; m_len = 0; m_tc = 0; m_dst = 0;
    end else if (m_busy) begin
      if (m_ov()) begin
        if (out_ready) begin
          m_rd++; m_dst += 2; m_tc--; m_len--;
        end
      end else begin
        mq.delete(); m_busy = 0; m_full = 0;
        if (m_len == 0) m_req = 0;
        if (m_tc == 0) m_end = 1;
      end
    end else begin
      bit st, rdy;
      st  = m_start();
      rdy = m_inrdy();
      if (reg_we && reg_sel == 2'd0) m_len = reg_wdata & 16'hFFFC;
      if (reg_we && reg_sel == 2'd1) begin
        m_req = reg_wdata[2]; m_rev = reg_wdata[0];
      end
      if (cfg_we) begin
        m_dst = cfg_dst; m_tc = cfg_cnt; m_end = 0;
      end
      if (in_valid && rdy && m_req) begin
        mq.push_back(in_data);
        if (mq.size() == 8) m_full = 1;
      end
      if (st) begin
        m_busy = 1; m_rd = 0;
      end
    end
  end

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      chk("R4", "in_ready", in_ready, m_inrdy());
      chk("R5", "busy", busy, m_busy);
      chk("R6", "out_valid", out_valid, m_ov());
      chk("R6", "out_addr", out_addr, m_dst);
      if (m_ov()) chk("R3", "out_data", out_data, mq[m_rd]);
      chk("R10", "fifo_full", fifo_full, m_full);
      chk("R8", "req_en", req_en, m_req);
      chk("R2", "rev_mode", rev_mode, m_rev);
      chk("R1", "len_left", len_left, m_len);
      chk("R6", "xfer_left", xfer_left, m_tc);
      chk("R9", "ch_end", ch_end, m_end);
    end
  end

  task automatic finish_run();
    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done_flag) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
      finish_run();
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask
  task automatic regw(logic [1:0] s, logic [15:0] d);
    reg_we = 1; reg_sel = s; reg_wdata = d; step(); reg_we = 0;
  endtask
  task automatic cfgw(logic [31:0] a, logic [23:0] c);
    cfg_we = 1; cfg_dst = a; cfg_cnt = c; step(); cfg_we = 0;
  endtask
  task automatic send(logic [15:0] d);
    in_valid = 1; in_data = d;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    step(); in_valid = 0;
  endtask
  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1;
    @(negedge clk);
    // R12: reset state
    chk("R12", "len", len_left, 0);
    chk("R12", "req", req_en, 0);
    chk("R12", "in_ready", in_ready, 1);
    chk("R12", "out_valid", out_valid, 0);
    chk("R12", "addr", out_addr, 0);
    step();
    // R1: low bits cleared
    regw(2'd0, 16'h0013);
    @(negedge clk); chk("R1", "len", len_left, 16'h0010);
    step();
    ch_mode = 2'b01; dma_en = 1;
    cfgw(32'h1000, 24'd16);
    // R3: dropped while request mode off
    send(16'hDEAD); send(16'hBEEF);
    @(negedge clk); chk("R3", "busy", busy, 0);
    step();
    regw(2'd1, 16'h0005);
    @(negedge clk); chk("R2", "req", req_en, 1); chk("R2", "rev", rev_mode, 1);
    step();
    out_ready = 0;
    for (int i = 0; i < 4; i++) send(16'hA000 + 16'(i));
    step();
    @(negedge clk);
    chk("R3", "first word", out_data, 16'hA000);
    chk("R5", "busy", busy, 1);
    repeat (3) @(negedge clk);
    chk("R6", "held data", out_data, 16'hA000);
    chk("R6", "held valid", out_valid, 1);
    step();
    out_ready = 1;
    wait_idle();
    chk("R6", "addr", out_addr, 32'h1008);
    chk("R6", "len", len_left, 16'h000C);
    chk("R7", "in_ready", in_ready, 1);
    step();
    // R10/R4: fill without arming
    ch_mode = 2'b00;
    for (int i = 0; i < 8; i++) send(16'hB000 + 16'(i));
    @(negedge clk);
    chk("R10", "full", fifo_full, 1);
    chk("R4", "in_ready", in_ready, 0);
    chk("R5", "busy", busy, 0);
    step();
    regw(2'd1, 16'h0004);
    @(negedge clk);
    chk("R2", "full kept", fifo_full, 1);
    chk("R2", "rev", rev_mode, 0);
    step();
    out_ready = 0;
    ch_mode = 2'b01;
    step(); step();
    // R11: writes ignored while busy
    regw(2'd0, 16'h0100);
    cfgw(32'h2000, 24'd5);
    @(negedge clk);
    chk("R11", "len", len_left, 16'h000C);
    chk("R11", "addr", out_addr, 32'h1008);
    step();
    out_ready = 1;
    wait_idle();
    chk("R7", "full clear", fifo_full, 0);
    chk("R6", "len", len_left, 16'h0004);
    chk("R6", "addr", out_addr, 32'h1018);
    step();
    for (int i = 0; i < 4; i++) send(16'hC000 + 16'(i));
    wait_idle();
    chk("R8", "req cleared", req_en, 0);
    chk("R9", "end set", ch_end, 1);
    step();
    cfgw(32'h3000, 24'd2);
    @(negedge clk); chk("R9", "end cleared", ch_end, 0);
    step();
    regw(2'd0, 16'h0008);
    regw(2'd1, 16'h0004);
    for (int i = 0; i < 4; i++) send(16'hD000 + 16'(i));
    wait_idle();
    chk("R7", "addr", out_addr, 32'h3004);
    chk("R7", "len", len_left, 16'h0006);
    chk("R7", "in_ready", in_ready, 1);
    chk("R9", "end", ch_end, 1);
    chk("R8", "req kept", req_en, 1);
    step();
    // Random phase, model compared every cycle
    regw(2'd0, 16'h0400);
    regw(2'd1, 16'h0004);
    cfgw(32'h4000, 24'd300);
    for (int i = 0; i < 600; i++) begin
      in_valid  = ($urandom % 3) != 0;
      in_data   = 16'($urandom);
      out_ready = ($urandom % 4) != 0;
      if ((i % 37) == 0) ch_mode = 2'($urandom);
      if ((i % 53) == 0) dma_en = ($urandom % 4) != 0;
      if ((i % 91) == 0) begin
        reg_we = 1; reg_sel = 2'd1; reg_wdata = 16'h0004 | 16'($urandom % 2);
      end else reg_we = 0;
      step();
    end
    in_valid = 0; reg_we = 0;
    repeat (5) step();
    finish_run();
  end
endmodule